// File: doc/BRIEF.md
# Multi-Character Transmit Queue with Ready Thresholds

This block is the transmit queue of a serial port. A host or a DMA engine writes characters into it either one byte at a time or as a 32-bit word that carries four characters. The queue hands characters, oldest first, to a byte-wide valid/ready output that feeds a serializer.

A transmit request output tells the DMA engine when there is room. The threshold is programmable: either one free entry or four free entries, so a four-character word transfer is only requested when the whole word fits. A receive request output applies the same kind of threshold, selected separately, to a receive occupancy count supplied from outside.

A queue enable input selects between multi-character operation and a single-entry legacy mode. In legacy mode the capacity collapses to one entry, both thresholds fall back to one, and the two threshold-mode readback outputs show zero. A clear input empties the queue in one cycle. A write that does not fit is discarded as a whole and latches a sticky overflow flag.

Top module: `sertx_mdfifo`

## Requirements
- R1: With `wr_word`=0, a write (`wr_en`=1) that is accepted enqueues exactly one character, taken from `wr_data[7:0]`.
- R2: With `wr_word`=1, an accepted write enqueues four characters in the order `wr_data[7:0]`, `[15:8]`, `[23:16]`, `[31:24]`; the lowest byte leaves the queue first.
- R3: A write whose character count (1 or 4) exceeds the free entries is discarded whole: `level` stays unchanged and `ovf` goes to 1 on the next cycle and stays at 1 until `clr` or reset.
- R4: With `fifo_en`=1 and `tx_mode`=0 (one-character threshold), `tx_req` is 1 exactly when at least one entry is free.
- R5: With `fifo_en`=1 and `tx_mode`=1 (four-character threshold), `tx_req` is 1 exactly when at least four entries are free.
- R6: `rx_req` is 1 when `rx_level` is at least 1 (`rx_mode`=0) or at least 4 (`rx_mode`=1, with `fifo_en`=1). This holds whatever `tx_mode` is, and `tx_mode_rd`/`rx_mode_rd` show the selected modes while enabled.
- R7: With `fifo_en`=0, the capacity is one entry, both thresholds are one regardless of `tx_mode`/`rx_mode`, `tx_mode_rd` and `rx_mode_rd` read 0, and a word write is always discarded.
- R8: `clr`=1 empties the queue at the next clock edge (`level`=0, `out_valid`=0), clears `ovf`, and discards any write in the same cycle.
- R9: `out_valid` is 1 exactly when `level` is nonzero, and `out_data` is the oldest character. A cycle with `out_valid` and `out_ready` both 1 removes it. Room for a write is judged on the occupancy before a removal in the same cycle.
- R10: After reset, `level`=0, `out_valid`=0, `ovf`=0 and `tx_req`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| fifo_en | input | 1 | 1 = multi-character queue, 0 = single-entry legacy mode |
| tx_mode | input | 1 | Transmit threshold: 0 = one entry free, 1 = four entries free |
| rx_mode | input | 1 | Receive threshold: 0 = one entry held, 1 = four entries held |
| wr_en | input | 1 | Write strobe for the data register |
| wr_word | input | 1 | Write size: 0 = byte, 1 = 32-bit word of four characters |
| wr_data | input | 32 | Write data, lowest byte first |
| clr | input | 1 | Empty the queue and clear the overflow flag |
| out_ready | input | 1 | Serializer accepts the current character |
| rx_level | input | 4 | Receive-side occupancy count |
| out_valid | output | 1 | A character is available |
| out_data | output | 8 | Oldest character |
| level | output | 4 | Number of characters held |
| tx_req | output | 1 | Transmit DMA request per threshold |
| rx_req | output | 1 | Receive DMA request per threshold |
| tx_mode_rd | output | 1 | Transmit threshold readback, 0 when disabled |
| rx_mode_rd | output | 1 | Receive threshold readback, 0 when disabled |
| ovf | output | 1 | Sticky overflow flag |

## Verification
Byte writes and word writes are drained through the output and compared in order. This separates a lane-order fault from a count fault: a swapped byte shows up only on word writes. The queue is filled to the boundary occupancies for each threshold, where free space is exactly four and then three, and exactly one and then zero. At those points `tx_req` tells a one-entry threshold apart from a four-entry one, and an accepted write apart from a dropped one. A write into a full queue while it is being drained shows that room is judged before the same-cycle removal. Legacy mode with both thresholds set to four shows that the mode fields are ignored and that capacity falls to one.

// File: rtl/sertx_pkg.sv
package sertx_pkg;

   typedef enum logic {
      THR_ONE  = 1'b0,
      THR_FOUR = 1'b1
   } thr_mode_e;

   localparam int unsigned CHAR_W     = 8;
   localparam int unsigned WORD_LANES = 4;

   function automatic bit is_pow2(int unsigned v);
      return (v != 0) && ((v & (v - 1)) == 0);
   endfunction

endpackage

// File: rtl/sertx_wrdecode.sv
module sertx_wrdecode #(
   parameter int unsigned DW    = 8,
   parameter int unsigned LANES = 4,
   parameter int unsigned CW    = 4
) (
   input  logic                         wr_en,
   input  logic                         wr_word,
   input  logic [DW*LANES-1:0]          wr_data,
   output logic [LANES-1:0][DW-1:0]     lane_data,
   output logic [CW-1:0]                push_n
);

   for (genvar g = 0; g < LANES; g++) begin : g_lane
      assign lane_data[g] = wr_data[g*DW +: DW];
   end

   always_comb begin
      if (!wr_en)       push_n = '0;
      else if (wr_word) push_n = CW'(LANES);
      else              push_n = CW'(1);
   end

endmodule

// File: rtl/sertx_thresh.sv
module sertx_thresh
   import sertx_pkg::*;
#(
   parameter int unsigned CW    = 4,
   parameter int unsigned MULTI = 4
) (
   input  logic          en,
   input  thr_mode_e     mode,
   input  logic [CW-1:0] amount,
   output logic          ready,
   output logic          mode_rd
);

   logic [CW-1:0] need;

   always_comb begin
      if (en && (mode == THR_FOUR)) need = CW'(MULTI);
      else                          need = CW'(1);
   end

   assign ready   = (amount >= need);
   assign mode_rd = en ? logic'(mode) : 1'b0;

endmodule

// File: rtl/sertx_store.sv
module sertx_store #(
   parameter int unsigned DW    = 8,
   parameter int unsigned DEPTH = 8,
   parameter int unsigned LANES = 4,
   parameter int unsigned CW    = 4,
   localparam int unsigned AW   = $clog2(DEPTH)
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     clr,
   input  logic [CW-1:0]            cap,
   input  logic [CW-1:0]            push_n,
   input  logic [LANES-1:0][DW-1:0] lane_data,
   input  logic                     pop_rq,
   output logic                     accept,
   output logic                     drop,
   output logic [CW-1:0]            level,
   output logic [CW-1:0]            free,
   output logic [DW-1:0]            rd_data,
   output logic                     nonempty
);

   logic [DW-1:0] mem [DEPTH];
   logic [AW-1:0] wr_ptr, rd_ptr;
   logic          pop;
   logic [CW-1:0] add_n;

   assign free     = (level >= cap) ? '0 : (cap - level);
   assign accept   = !clr && (push_n != '0) && (push_n <= free);
   assign drop     = !clr && (push_n != '0) && (push_n > free);
   assign nonempty = (level != '0);
   assign pop      = !clr && pop_rq && nonempty;
   assign add_n    = accept ? push_n : '0;
   assign rd_data  = mem[rd_ptr];

   always_ff @(posedge clk) begin
      if (accept) begin
         for (int l = 0; l < LANES; l++) begin
            if (CW'(l) < push_n) mem[wr_ptr + AW'(l)] <= lane_data[l];
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         level  <= '0;
      end else if (clr) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         level  <= '0;
      end else begin
         wr_ptr <= wr_ptr + AW'(add_n);
         if (pop) rd_ptr <= rd_ptr + AW'(1);
         level  <= level + add_n - (pop ? CW'(1) : CW'(0));
      end
   end

endmodule

// File: rtl/sertx_mdfifo.sv
module sertx_mdfifo
   import sertx_pkg::*;
#(
   parameter int unsigned DW    = CHAR_W,
   parameter int unsigned LANES = WORD_LANES,
   parameter int unsigned DEPTH = 8,
   localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                fifo_en,
   input  logic                tx_mode,
   input  logic                rx_mode,
   input  logic                wr_en,
   input  logic                wr_word,
   input  logic [DW*LANES-1:0] wr_data,
   input  logic                clr,
   input  logic                out_ready,
   input  logic [CW-1:0]       rx_level,
   output logic                out_valid,
   output logic [DW-1:0]       out_data,
   output logic [CW-1:0]       level,
   output logic                tx_req,
   output logic                rx_req,
   output logic                tx_mode_rd,
   output logic                rx_mode_rd,
   output logic                ovf
);

   if (!is_pow2(DEPTH)) begin : g_bad_depth
      $error("sertx_mdfifo: DEPTH must be a power of two");
   end
   if (DEPTH < LANES) begin : g_bad_fit
      $error("sertx_mdfifo: DEPTH must hold at least one full word");
   end
   if (LANES < 2) begin : g_bad_lanes
      $error("sertx_mdfifo: LANES must be at least two");
   end

   logic [LANES-1:0][DW-1:0] lane_data;
   logic [CW-1:0]            push_n;
   logic [CW-1:0]            cap;
   logic [CW-1:0]            free;
   logic                     accept, drop, nonempty;

   assign cap = fifo_en ? CW'(DEPTH) : CW'(1);

   sertx_wrdecode #(.DW(DW), .LANES(LANES), .CW(CW)) u_dec (
      .wr_en     (wr_en),
      .wr_word   (wr_word),
      .wr_data   (wr_data),
      .lane_data (lane_data),
      .push_n    (push_n)
   );

   sertx_store #(.DW(DW), .DEPTH(DEPTH), .LANES(LANES), .CW(CW)) u_store (
      .clk       (clk),
      .rst_n     (rst_n),
      .clr       (clr),
      .cap       (cap),
      .push_n    (push_n),
      .lane_data (lane_data),
      .pop_rq    (out_ready),
      .accept    (accept),
      .drop      (drop),
      .level     (level),
      .free      (free),
      .rd_data   (out_data),
      .nonempty  (nonempty)
   );

   sertx_thresh #(.CW(CW), .MULTI(LANES)) u_tx_thr (
      .en      (fifo_en),
      .mode    (thr_mode_e'(tx_mode)),
      .amount  (free),
      .ready   (tx_req),
      .mode_rd (tx_mode_rd)
   );

   sertx_thresh #(.CW(CW), .MULTI(LANES)) u_rx_thr (
      .en      (fifo_en),
      .mode    (thr_mode_e'(rx_mode)),
      .amount  (rx_level),
      .ready   (rx_req),
      .mode_rd (rx_mode_rd)
   );

   assign out_valid = nonempty;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    ovf <= 1'b0;
      else if (clr)  ovf <= 1'b0;
      else if (drop) ovf <= 1'b1;
   end

   logic unused_accept;
   assign unused_accept = accept;

endmodule

module sertx_mdfifo_chk #(
   parameter int unsigned DW    = 8,
   parameter int unsigned LANES = 4,
   parameter int unsigned DEPTH = 8,
   parameter int unsigned CW    = 4
) (
   input logic                clk,
   input logic                rst_n,
   input logic                fifo_en,
   input logic                tx_mode,
   input logic                wr_en,
   input logic                wr_word,
   input logic                clr,
   input logic                out_ready,
   input logic                out_valid,
   input logic [CW-1:0]       level,
   input logic                tx_req,
   input logic                tx_mode_rd,
   input logic                rx_mode_rd,
   input logic                ovf
);

   logic popping;
   assign popping = out_valid && out_ready;

   AST_LEVEL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      int'(level) <= DEPTH); // R9

   AST_VALID_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid == (level != '0)); // R9

   AST_WORD_GROWTH: assert property (@(posedge clk) disable iff (!rst_n)
      (fifo_en && wr_en && wr_word && !clr && !popping && (int'(level) + LANES <= DEPTH))
      |=> (int'(level) == int'($past(level)) + LANES)); // R2

   AST_WORD_DROP: assert property (@(posedge clk) disable iff (!rst_n)
      (fifo_en && wr_en && wr_word && !clr && !popping && (int'(level) + LANES > DEPTH))
      |=> (level == $past(level)) && ovf); // R3

   AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (ovf && !clr) |=> ovf); // R3

   AST_CLEAR_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (level == '0) && !ovf && !out_valid); // R8

   AST_FOUR_ROOM: assert property (@(posedge clk) disable iff (!rst_n)
      (fifo_en && tx_mode && tx_req) |-> (int'(level) + LANES <= DEPTH)); // R5

   AST_DIS_READBACK: assert property (@(posedge clk) disable iff (!rst_n)
      !fifo_en |-> (!tx_mode_rd && !rx_mode_rd)); // R7

   AST_DIS_CAPACITY: assert property (@(posedge clk) disable iff (!rst_n)
      (!fifo_en && $past(!fifo_en) && !$past(clr)) |-> (int'(level) <= 1 || $stable(level))); // R7

endmodule

bind sertx_mdfifo sertx_mdfifo_chk #(.DW(DW), .LANES(LANES), .DEPTH(DEPTH), .CW(CW)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .fifo_en    (fifo_en),
   .tx_mode    (tx_mode),
   .wr_en      (wr_en),
   .wr_word    (wr_word),
   .clr        (clr),
   .out_ready  (out_ready),
   .out_valid  (out_valid),
   .level      (level),
   .tx_req     (tx_req),
   .tx_mode_rd (tx_mode_rd),
   .rx_mode_rd (rx_mode_rd),
   .ovf        (ovf)
);

// File: tb/sertx_mdfifo_tb.sv
module sertx_mdfifo_tb;

   localparam int CLK_PERIOD = 10;
   localparam int DEPTH      = 8;
   localparam int CW         = $clog2(DEPTH + 1);

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          fifo_en = 1'b1, tx_mode = 1'b0, rx_mode = 1'b0;
   logic          wr_en = 1'b0, wr_word = 1'b0, clr = 1'b0, out_ready = 1'b0;
   logic [31:0]   wr_data = '0;
   logic [CW-1:0] rx_level = '0;
   logic          out_valid, tx_req, rx_req, tx_mode_rd, rx_mode_rd, ovf;
   logic [7:0]    out_data;
   logic [CW-1:0] level;

   logic [7:0]    sb_q[$];
   int            checks = 0;
   int            errors = 0;
   bit            exp_ovf = 1'b0;
   bit            done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   sertx_mdfifo #(.DEPTH(DEPTH)) u_dut (
      .clk(clk), .rst_n(rst_n), .fifo_en(fifo_en), .tx_mode(tx_mode), .rx_mode(rx_mode),
      .wr_en(wr_en), .wr_word(wr_word), .wr_data(wr_data), .clr(clr), .out_ready(out_ready),
      .rx_level(rx_level), .out_valid(out_valid), .out_data(out_data), .level(level),
      .tx_req(tx_req), .rx_req(rx_req), .tx_mode_rd(tx_mode_rd), .rx_mode_rd(rx_mode_rd),
      .ovf(ovf)
   );

   task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   function automatic int cap_now();
      return fifo_en ? DEPTH : 1;
   endfunction

   function automatic bit exp_tx_req();
      int need = (fifo_en && tx_mode) ? 4 : 1;
      return (cap_now() - sb_q.size()) >= need;
   endfunction

   task automatic tick();
      @(posedge clk);
      #1;
   endtask

   task automatic put_byte(input logic [7:0] b);
      wr_en = 1'b1; wr_word = 1'b0; wr_data = {24'h5A5A5A, b};
      if (sb_q.size() < cap_now()) sb_q.push_back(b);
      else exp_ovf = 1'b1;
      tick();
      wr_en = 1'b0;
   endtask

   task automatic put_word(input logic [31:0] w);
      wr_en = 1'b1; wr_word = 1'b1; wr_data = w;
      if (cap_now() - sb_q.size() >= 4) begin
         for (int i = 0; i < 4; i++) sb_q.push_back(w[i*8 +: 8]);
      end else begin
         exp_ovf = 1'b1;
      end
      tick();
      wr_en = 1'b0; wr_word = 1'b0;
   endtask

   task automatic check_state(input string req);
      chk(int'(level) == sb_q.size(), req, "level", int'(level), sb_q.size());
      chk(tx_req == exp_tx_req(), req, "tx_req", int'(tx_req), int'(exp_tx_req()));
      chk(ovf == exp_ovf, req, "ovf", int'(ovf), int'(exp_ovf));
   endtask

   task automatic drain();
      out_ready = 1'b1;
      while (sb_q.size() != 0) @(posedge clk);
      #1;
      out_ready = 1'b0;
      chk(out_valid == 1'b0, "R9", "out_valid after drain", int'(out_valid), 0);
   endtask

   // scoreboard monitor: a character is removed at the edge after it is seen here
   always @(negedge clk) begin
      if (rst_n && out_valid && out_ready) begin
         if (sb_q.size() == 0) begin
            chk(1'b0, "R9", "unexpected character", int'(out_data), -1);
         end else begin
            logic [7:0] e;
            e = sb_q.pop_front();
            chk(out_data == e, "R1 R2 R9", "character order", int'(out_data), int'(e));
         end
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      #1;
      // R10 reset state
      chk(level == '0, "R10", "level", int'(level), 0);
      chk(out_valid == 1'b0, "R10", "out_valid", int'(out_valid), 0);
      chk(ovf == 1'b0, "R10", "ovf", int'(ovf), 0);
      rst_n = 1'b1;
      tick();
      chk(tx_req == 1'b1, "R10", "tx_req", int'(tx_req), 1);

      // R1 byte writes
      put_byte(8'h11); put_byte(8'h22); put_byte(8'h33);
      check_state("R1");
      drain();

      // R2 word write, lowest byte first
      put_word(32'h44332211);
      check_state("R2");
      put_word(32'hD4C3B2A1);
      check_state("R2");
      drain();

      // R5 four-character threshold around four free
      tx_mode = 1'b1;
      put_word(32'h04030201);
      check_state("R5");
      chk(tx_req == 1'b1, "R5", "tx_req at four free", int'(tx_req), 1);
      put_byte(8'h05);
      check_state("R5");
      chk(tx_req == 1'b0, "R5", "tx_req at three free", int'(tx_req), 0);
      // R3 word with three free is dropped whole
      put_word(32'hEEEEEEEE);
      check_state("R3");
      chk(ovf == 1'b1, "R3", "ovf after word drop", int'(ovf), 1);
      put_byte(8'h06);
      check_state("R3");

      // R4 one-character threshold around one free
      tx_mode = 1'b0;
      #1;
      chk(tx_req == 1'b1, "R4", "tx_req at two free", int'(tx_req), 1);
      put_byte(8'h07);
      check_state("R4");
      put_byte(8'h08);
      check_state("R4");
      chk(tx_req == 1'b0, "R4", "tx_req at full", int'(tx_req), 0);
      put_byte(8'hEE);
      check_state("R3");

      // R8 clear with a simultaneous write
      clr = 1'b1; wr_en = 1'b1; wr_data = 32'h000000AB;
      tick();
      clr = 1'b0; wr_en = 1'b0;
      sb_q.delete(); exp_ovf = 1'b0;
      check_state("R8");
      chk(out_valid == 1'b0, "R8", "out_valid after clear", int'(out_valid), 0);

      // R9 write into a full queue while draining is judged before the removal
      put_word(32'h24232221); put_word(32'h28272625);
      check_state("R9");
      out_ready = 1'b1;
      put_byte(8'hEE);
      chk(ovf == 1'b1, "R9", "ovf on full-while-draining", int'(ovf), 1);
      put_byte(8'h29);
      chk(int'(level) == DEPTH - 1, "R9", "level push+pop", int'(level), DEPTH - 1);
      drain();
      clr = 1'b1; tick(); clr = 1'b0; exp_ovf = 1'b0;

      // R6 receive threshold independent of transmit mode
      tx_mode = 1'b1; rx_mode = 1'b0; rx_level = CW'(1);
      #1;
      chk(rx_req == 1'b1, "R6", "rx_req one mode level 1", int'(rx_req), 1);
      chk(tx_mode_rd == 1'b1 && rx_mode_rd == 1'b0, "R6", "mode readback", int'({tx_mode_rd, rx_mode_rd}), 2);
      rx_mode = 1'b1; rx_level = CW'(3);
      #1;
      chk(rx_req == 1'b0, "R6", "rx_req four mode level 3", int'(rx_req), 0);
      rx_level = CW'(4);
      #1;
      chk(rx_req == 1'b1, "R6", "rx_req four mode level 4", int'(rx_req), 1);

      // R7 disabled: readback zero, thresholds one, capacity one
      fifo_en = 1'b0; rx_level = CW'(1);
      tick();
      chk(tx_mode_rd == 1'b0 && rx_mode_rd == 1'b0, "R7", "mode readback", int'({tx_mode_rd, rx_mode_rd}), 0);
      chk(rx_req == 1'b1, "R7", "rx_req threshold one", int'(rx_req), 1);
      check_state("R7");
      chk(tx_req == 1'b1, "R7", "tx_req empty", int'(tx_req), 1);
      put_word(32'h33333333);
      check_state("R7");
      put_byte(8'h3C);
      check_state("R7");
      put_byte(8'hEE);
      check_state("R7");
      drain();

      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule